// File: doc/BRIEF.md
# Serial Flash Clock and Chip-Select Timing Generator

This block makes the serial clock and the active-low chip-select lines for a four-lane serial flash port. A frame sequencer tells it when a transfer starts and ends with single-cycle strobes. It returns a one-cycle enable on each leading clock edge (leaving the idle level) and each trailing clock edge (returning to the idle level), so the sequencer can shift and sample data in step with the pins.

An 8-bit prescale value sets the clock period in system cycles. A clock-mode bit picks low or high as the idle level, which gives SPI mode 0 or mode 3. A device-select bit picks which of two flash parts gets its select line driven low. After each frame the block keeps the interface busy for a programmed number of whole serial-clock periods. This holds the select high for a minimum deselect time before the next frame can begin.

The configuration inputs are meant to change only while the busy output is low. The block captures them on every idle cycle and holds the captured copy for the whole frame and the deselect time that follows it.

Top module: `flash_sclk_cs_gen`

## Requirements
- R1: With prescale value N, the serial clock period is N+1 system cycles for N from 1 to 255. N = 0 gives a period of 2 cycles, so each phase lasts one system cycle.
- R2: In a clock period P, the high phase lasts ceil(P/2) cycles and the low phase lasts floor(P/2) cycles. Each period begins with the idle-level phase.
- R3: Clock-mode input 0 gives a low idle level and 1 gives a high idle level. When no frame is active the clock sits at the idle level. In the idle state it follows a change of the mode input one cycle later.
- R4: Chip selects are active low. Device-select 0 drives cs_n[0] low and device-select 1 drives cs_n[1] low. At most one select line is low at any time.
- R5: A start strobe sampled while idle gives busy high and the chosen select low in the next cycle. The first leading clock edge appears idle-phase-length cycles after that.
- R6: An end strobe gives, in the next cycle, both select lines high and the clock at its idle level. No further clock edge or edge enable follows.
- R7: After the select lines rise, busy stays high for exactly (D+1)*P system cycles, where D is the 3-bit deselect value. A start strobe while busy is ignored.
- R8: Changes to the prescale, mode, deselect or device-select inputs while busy do not affect the running frame or its deselect time.
- R9: The lead-edge enable is high for exactly one cycle in each cycle where the clock first shows its non-idle level. The trail-edge enable does the same where the clock first shows its idle level again. The clock never changes while busy unless one of the two enables is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_presc_i | input | PRESC_W | Prescale value N |
| cfg_idle_high_i | input | 1 | Clock mode: 0 idle low, 1 idle high |
| cfg_dev_i | input | SEL_W | Flash device select |
| cfg_desel_i | input | DESEL_W | Deselect time D, in (D+1) serial-clock periods |
| frame_start_i | input | 1 | One-cycle frame start strobe |
| frame_end_i | input | 1 | One-cycle frame end strobe |
| busy_o | output | 1 | High from frame start until the deselect time has passed |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | NUM_CS | Active-low chip selects |
| lead_en_o | output | 1 | Leading-edge enable |
| trail_en_o | output | 1 | Trailing-edge enable |

## Verification
The bench counts timing from the start strobe. If the start strobe is sampled at edge s, busy and the select change at s. The k-th leading edge falls at s + k*P + L, where L is the idle-phase length, and the k-th trailing edge at s + (k+1)*P. An end strobe sampled at edge e raises the select at e, and busy falls at e + (D+1)*P. The driver computes each of these edge numbers before it drives the strobe and queues them with the expected level. The monitor samples on the falling clock edge, stamps each observed change with the count of rising edges so far, and requires both the stamp and the value to match the head of the queue.

// File: rtl/fscg_pkg.sv
package fscg_pkg;

   // Interface phase of the timing generator
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACTIVE = 2'd1,
      ST_HOLD   = 2'd2
   } fscg_state_e;

endpackage

// File: rtl/fscg_divider.sv
// Serial clock divider: phase counter, level register and edge enables.
module fscg_divider #(
   parameter int PRESC_W = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [PRESC_W-1:0] presc_i,
   input  logic               idle_lvl_i,
   input  logic               count_en_i,
   input  logic               toggle_en_i,
   output logic               sclk_o,
   output logic               lead_o,
   output logic               trail_o,
   output logic               wrap_o
);
   localparam int CW = PRESC_W + 1;

   if (PRESC_W < 1) begin : g_bad_width
      $error("fscg_divider: PRESC_W must be at least 1");
   end

   logic [PRESC_W-1:0] cnt_q;
   logic [PRESC_W-1:0] last_idx;
   logic [CW-1:0]      hi_len;
   logic [CW-1:0]      lo_len;
   logic [CW-1:0]      idle_len;
   logic               at_mid;
   logic               at_last;

   // period - 1; a zero prescale is stretched to a two-cycle period
   assign last_idx = (presc_i == '0) ? PRESC_W'(1) : presc_i;
   assign hi_len   = CW'(({1'b0, last_idx} + CW'(2)) >> 1);
   assign lo_len   = CW'(({1'b0, last_idx} + CW'(1)) >> 1);
   assign idle_len = idle_lvl_i ? hi_len : lo_len;
   assign at_mid   = ({1'b0, cnt_q} == (idle_len - CW'(1)));
   assign at_last  = (cnt_q == last_idx);
   assign wrap_o   = count_en_i && at_last;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!count_en_i) begin
         cnt_q <= '0;
      end else if (at_last) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + PRESC_W'(1);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sclk_o  <= 1'b0;
         lead_o  <= 1'b0;
         trail_o <= 1'b0;
      end else begin
         lead_o  <= toggle_en_i && at_mid;
         trail_o <= toggle_en_i && at_last;
         if (!toggle_en_i) begin
            sclk_o <= idle_lvl_i;
         end else if (at_mid) begin
            sclk_o <= ~idle_lvl_i;
         end else if (at_last) begin
            sclk_o <= idle_lvl_i;
         end
      end
   end

   AST_EDGE_MOVES_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lead_o || trail_o) |-> (sclk_o != $past(sclk_o))); // R9
   AST_ONE_EDGE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(lead_o && trail_o)); // R9
   AST_CNT_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_en_i |-> (cnt_q <= last_idx)); // R1

endmodule

// File: rtl/fscg_desel_timer.sv
// Counts whole serial-clock periods of the deselect interval.
module fscg_desel_timer #(
   parameter int DESEL_W = 3
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               run_i,
   input  logic               wrap_i,
   input  logic [DESEL_W-1:0] limit_i,
   output logic               done_o
);
   if (DESEL_W < 1) begin : g_bad_width
      $error("fscg_desel_timer: DESEL_W must be at least 1");
   end

   logic [DESEL_W-1:0] per_q;

   assign done_o = run_i && wrap_i && (per_q == limit_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         per_q <= '0;
      end else if (!run_i) begin
         per_q <= '0;
      end else if (wrap_i) begin
         per_q <= per_q + DESEL_W'(1);
      end
   end

   AST_HOLD_WITHIN_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i |-> (per_q <= limit_i)); // R7

endmodule

// File: rtl/fscg_select.sv
// Registered one-of-N active-low chip-select decode.
module fscg_select #(
   parameter int NUM_CS = 2,
   parameter int SEL_W  = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              drive_i,
   input  logic [SEL_W-1:0]  dev_i,
   output logic [NUM_CS-1:0] cs_n_o
);
   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cs_n_o[i] <= 1'b1;
         end else begin
            cs_n_o[i] <= !(drive_i && (dev_i == SEL_W'(i)));
         end
      end
   end

   AST_CS_ONE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(~cs_n_o)); // R4

endmodule

// File: rtl/flash_sclk_cs_gen.sv
// Serial flash clock and chip-select timing generator (top).
module flash_sclk_cs_gen
   import fscg_pkg::*;
#(
   parameter int PRESC_W = 8,
   parameter int DESEL_W = 3,
   parameter int NUM_CS  = 2,
   parameter int SEL_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [PRESC_W-1:0] cfg_presc_i,
   input  logic               cfg_idle_high_i,
   input  logic [SEL_W-1:0]   cfg_dev_i,
   input  logic [DESEL_W-1:0] cfg_desel_i,
   input  logic               frame_start_i,
   input  logic               frame_end_i,
   output logic               busy_o,
   output logic               sclk_o,
   output logic [NUM_CS-1:0]  cs_n_o,
   output logic               lead_en_o,
   output logic               trail_en_o
);
   if (NUM_CS < 2) begin : g_bad_cs
      $error("flash_sclk_cs_gen: NUM_CS must be at least 2");
   end
   if (SEL_W < $clog2(NUM_CS)) begin : g_bad_sel
      $error("flash_sclk_cs_gen: SEL_W too narrow for NUM_CS");
   end

   fscg_state_e        state_q, state_d;
   logic [PRESC_W-1:0] presc_q, presc_eff;
   logic               mode_q, mode_eff;
   logic [SEL_W-1:0]   dev_q, dev_eff;
   logic [DESEL_W-1:0] desel_q, desel_eff;
   logic               is_idle, is_active, is_hold;
   logic               count_en, toggle_en, wrap, hold_done;

   assign is_idle   = (state_q == ST_IDLE);
   assign is_active = (state_q == ST_ACTIVE);
   assign is_hold   = (state_q == ST_HOLD);
   assign busy_o    = !is_idle;

   // Settings follow the inputs while idle and are frozen otherwise
   assign presc_eff = is_idle ? cfg_presc_i     : presc_q;
   assign mode_eff  = is_idle ? cfg_idle_high_i : mode_q;
   assign dev_eff   = is_idle ? cfg_dev_i       : dev_q;
   assign desel_eff = is_idle ? cfg_desel_i     : desel_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         presc_q <= '0;
         mode_q  <= 1'b0;
         dev_q   <= '0;
         desel_q <= '0;
      end else if (is_idle) begin
         presc_q <= cfg_presc_i;
         mode_q  <= cfg_idle_high_i;
         dev_q   <= cfg_dev_i;
         desel_q <= cfg_desel_i;
      end
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (frame_start_i) state_d = ST_ACTIVE;
         ST_ACTIVE: if (frame_end_i)   state_d = ST_HOLD;
         ST_HOLD:   if (hold_done)     state_d = ST_IDLE;
         default:                      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   // The phase counter restarts when a frame ends so the deselect
   // interval is measured in whole periods from the select rising.
   assign count_en  = busy_o && !(is_active && frame_end_i);
   assign toggle_en = is_active && !frame_end_i;

   fscg_divider #(
      .PRESC_W (PRESC_W)
   ) i_divider (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .presc_i     (presc_eff),
      .idle_lvl_i  (mode_eff),
      .count_en_i  (count_en),
      .toggle_en_i (toggle_en),
      .sclk_o      (sclk_o),
      .lead_o      (lead_en_o),
      .trail_o     (trail_en_o),
      .wrap_o      (wrap)
   );

   fscg_desel_timer #(
      .DESEL_W (DESEL_W)
   ) i_desel (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (is_hold),
      .wrap_i  (wrap),
      .limit_i (desel_eff),
      .done_o  (hold_done)
   );

   fscg_select #(
      .NUM_CS (NUM_CS),
      .SEL_W  (SEL_W)
   ) i_select (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .drive_i (state_d == ST_ACTIVE),
      .dev_i   (dev_eff),
      .cs_n_o  (cs_n_o)
   );

   AST_CS_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(~cs_n_o)) |-> busy_o); // R5
   AST_HOLD_CLK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_hold |-> (sclk_o == mode_q)); // R3
   AST_HOLD_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_hold |-> (&cs_n_o)); // R6
   AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && $past(busy_o)) |-> ($stable(presc_q) && $stable(mode_q) && $stable(desel_q))); // R8
   AST_NO_EDGE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !(lead_en_o || trail_en_o)); // R9

endmodule

// File: tb/test_flash_sclk_cs_gen.sv
`timescale 1ns/1ps
module test_flash_sclk_cs_gen;

   typedef struct {
      int     kind;   // 0 busy rise, 1 cs change, 2 lead, 3 trail, 4 busy fall
      longint stamp;
      int     val;
      string  req;
   } ev_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] presc = 8'd0;
   logic       mode = 1'b0;
   logic       dev = 1'b0;
   logic [2:0] desel = 3'd0;
   logic       fstart = 1'b0;
   logic       fend = 1'b0;
   logic       busy, sclk, lead, trail;
   logic [1:0] cs_n;

   longint cyc = 0;
   int     checks = 0;
   int     fails = 0;
   bit     mon_on = 1'b0;
   bit     done = 1'b0;
   ev_t    exp_q[$];

   logic       p_busy, p_sclk;
   logic [1:0] p_cs;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   flash_sclk_cs_gen i_flash_sclk_cs_gen (
      .clk_i           (clk),
      .rst_ni          (rst_n),
      .cfg_presc_i     (presc),
      .cfg_idle_high_i (mode),
      .cfg_dev_i       (dev),
      .cfg_desel_i     (desel),
      .frame_start_i   (fstart),
      .frame_end_i     (fend),
      .busy_o          (busy),
      .sclk_o          (sclk),
      .cs_n_o          (cs_n),
      .lead_en_o       (lead),
      .trail_en_o      (trail)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic push(input int kind, input longint stamp, input int val, input string req);
      ev_t e;
      e.kind = kind; e.stamp = stamp; e.val = val; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic observe(input int kind, input int val);
      ev_t e;
      if (exp_q.size() == 0) begin
         chk(1'b0, "R7", "unexpected event kind", kind, -1);
         return;
      end
      e = exp_q.pop_front();
      chk(e.kind == kind, e.req, "event kind", kind, e.kind);
      chk(e.stamp == cyc, e.req, "event cycle", cyc, e.stamp);
      chk(e.val == val, e.req, "event value", val, e.val);
   endtask

   // Monitor: samples away from the active edge and compares in order
   always @(negedge clk) begin
      if (mon_on) begin
         if (busy !== p_busy) observe(busy ? 0 : 4, int'(busy));
         if (cs_n !== p_cs) observe(1, int'(cs_n));
         if (lead) observe(2, int'(sclk));
         if (trail) observe(3, int'(sclk));
         if (busy && p_busy && (sclk !== p_sclk) && !lead && !trail)
            chk(1'b0, "R9", "clock moved without enable", sclk, p_sclk);
      end
      p_busy = busy;
      p_cs   = cs_n;
      p_sclk = sclk;
   end

   // Driver: queues every expected change before driving the strobe
   task automatic run_frame(input int pv, input bit md, input bit sel,
                            input int dv, input int n, input bit perturb);
      int p, il;
      longint s, e, f;
      p  = (pv == 0) ? 2 : pv + 1;
      il = md ? (p + 1) / 2 : p / 2;
      @(negedge clk);
      presc = 8'(pv); mode = md; dev = sel; desel = 3'(dv);
      @(negedge clk);
      @(negedge clk);
      s = cyc + 1;
      push(0, s, 1, "R5");
      push(1, s, sel ? 1 : 2, "R4");
      for (int k = 0; k < n; k++) begin
         push(2, s + k * p + il, md ? 0 : 1, perturb ? "R8" : "R2 R9");
         push(3, s + (k + 1) * p, md ? 1 : 0, perturb ? "R8" : "R1");
      end
      e = s + n * p + 1;
      push(1, e, 3, "R6");
      f = e + (dv + 1) * p;
      push(4, f, 0, perturb ? "R8" : "R7");
      fstart = 1'b1;
      @(negedge clk);
      fstart = 1'b0;
      if (perturb) begin
         presc = presc ^ 8'h05; mode = ~md; desel = ~desel; dev = ~sel;
         fstart = 1'b1;
         @(negedge clk);
         fstart = 1'b0;
      end
      while (cyc < e - 1) @(negedge clk);
      fend = 1'b1;
      @(negedge clk);
      fend = 1'b0;
      if (perturb) begin
         fstart = 1'b1;
         @(negedge clk);
         fstart = 1'b0;
         presc = 8'(pv); mode = md; dev = sel; desel = 3'(dv);
      end
      while (cyc < f + 1) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n == 2'b11, "R4", "reset select lines", cs_n, 3);
      chk(busy == 1'b0, "R7", "reset busy", busy, 0);
      chk(sclk == 1'b0, "R3", "reset clock level", sclk, 0);
      chk(!lead && !trail, "R9", "reset edge enables", {lead, trail}, 0);
      // Idle level follows the mode input while idle
      mode = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(sclk == 1'b1, "R3", "idle level mode 3", sclk, 1);
      mode = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(sclk == 1'b0, "R3", "idle level mode 0", sclk, 0);
      p_busy = busy; p_cs = cs_n; p_sclk = sclk;
      mon_on = 1'b1;
      run_frame(0,   1'b0, 1'b0, 0, 3, 1'b0);
      run_frame(2,   1'b0, 1'b1, 2, 2, 1'b0);
      mon_on = 1'b0;
      mode = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(sclk == 1'b1, "R3", "idle level before mode 3 frame", sclk, 1);
      p_busy = busy; p_cs = cs_n; p_sclk = sclk;
      mon_on = 1'b1;
      run_frame(4,   1'b1, 1'b0, 7, 2, 1'b0);
      run_frame(1,   1'b1, 1'b1, 1, 4, 1'b1);
      run_frame(7,   1'b1, 1'b0, 3, 2, 1'b1);
      mon_on = 1'b0;
      mode = 1'b0;
      @(negedge clk);
      @(negedge clk);
      p_busy = busy; p_cs = cs_n; p_sclk = sclk;
      mon_on = 1'b1;
      run_frame(255, 1'b0, 1'b0, 0, 2, 1'b0);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R5", "expected events left over", exp_q.size(), 0);
      chk(busy == 1'b0 && cs_n == 2'b11, "R7", "final idle", {busy, cs_n}, 3);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R7 watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule